// File: doc/BRIEF.md
# Vector Register File with Upper-Lane Clear

This block holds a bank of wide vector registers, each `MAXVL` bits wide (512 by default). The 128-bit and 256-bit views of a register are simply its low-order bits, so there is one storage entry per register number. Two read ports return register contents combinationally. One write port updates a register at the clock edge, and a width select limits the update to the low 128 bits, the low 256 bits or the whole entry.

A bulk clear command zeroes every bit from position 128 upward in a range of registers. The range depends on a mode flag. The command also carries a 4-bit specifier field that must be all ones. If it is not, the block raises a fault output for that cycle and the clear has no effect.

A small command classifier sorts each cycle into one of four states: `CMD_IDLE` (no command, or reset active), `CMD_CLR_WIDE` (well-formed command, mode flag high), `CMD_CLR_NARROW` (well-formed command, mode flag low) and `CMD_BAD` (specifier not all ones). The classifier holds no state between cycles, so every cycle enters its state directly from the inputs and leaves it at the next edge. The state drives a per-register clear mask and the fault output. The storage applies the write merge first and then the mask.

Top module: `vec_regfile`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, every register becomes zero, and `ud_fault` is low while reset is high.
- R2: A well-formed clear (`clr_spec` = 4'b1111) with `clr_wide_mode` = 1 zeroes bits MAXVL-1..128 of registers 0 through 15 at that clock edge.
- R3: A well-formed clear with `clr_wide_mode` = 0 zeroes bits MAXVL-1..128 of registers 0 through 7 only; registers 8 through 15 keep their value.
- R4: The clear never alters bits 127..0 of any register.
- R5: Registers 16 through 31 are never changed by a clear command, in either mode and with any specifier.
- R6: A clear whose `clr_spec` is not 4'b1111 drives `ud_fault` high in the same cycle and changes no register through the clear; a write in that cycle still takes effect.
- R7: `ud_fault` is low in every cycle without a malformed clear, so it is a pulse lasting exactly the cycles in which the malformed command is presented.
- R8: `wr_width` = 2'b00 writes bits 127..0 only, 2'b01 writes bits 255..0 only, and 2'b10 or 2'b11 writes the full entry; bits outside the selected span keep their value.
- R9: When a write and a well-formed clear both reach a register in the clear's range in the same cycle, the write is merged first and then bits MAXVL-1..128 of that register are zeroed.
- R10: Both read ports are combinational on their index, and they show the result of a write or clear from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | MAXVL | Read port A contents |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | MAXVL | Read port B contents |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_width | input | 2 | Write span: 00 = 128 bits, 01 = 256 bits, 1x = full |
| wr_data | input | MAXVL | Write data |
| clr_req | input | 1 | Upper-lane clear command valid |
| clr_wide_mode | input | 1 | 1 selects registers 0..15, 0 selects registers 0..7 |
| clr_spec | input | 4 | Specifier field; must be 4'b1111 |
| ud_fault | output | 1 | Malformed-command fault, same cycle |

## Verification
The hardest case to reach from the ports is a write and a clear landing on the same register at the same edge. Close behind it is a malformed clear that coincides with a write, where the write must still land but the clear must not. Each bench operation drives the write fields and the clear fields together in one low clock phase. This lets the sweep aim a full-width write at registers inside the narrow range, inside the wide-only range and in the high bank, under both modes and under a good and a bad specifier. All 32 registers are then read back through both ports.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam logic [3:0] SPEC_OK = 4'b1111;

    typedef enum logic [1:0] {
        WW_128  = 2'b00,
        WW_256  = 2'b01,
        WW_FULL = 2'b10
    } wr_width_e;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_CLR_WIDE,
        CMD_CLR_NARROW,
        CMD_BAD
    } cmd_e;

endpackage

// File: rtl/vrf_cmd_decode.sv
module vrf_cmd_decode
    import vrf_pkg::*;
#(
    parameter int NREG       = 32,
    parameter int WIDE_CNT   = 16,
    parameter int NARROW_CNT = 8
) (
    input  logic            rst,
    input  logic            clr_req,
    input  logic            clr_wide_mode,
    input  logic [3:0]      clr_spec,
    output logic [NREG-1:0] clr_mask,
    output logic            fault
);

    cmd_e            cmd_state;
    logic [NREG-1:0] wide_set;
    logic [NREG-1:0] narrow_set;

    for (genvar i = 0; i < NREG; i++) begin : g_sets
        if (i < WIDE_CNT) begin : g_w
            assign wide_set[i] = 1'b1;
        end else begin : g_wn
            assign wide_set[i] = 1'b0;
        end
        if (i < NARROW_CNT) begin : g_n
            assign narrow_set[i] = 1'b1;
        end else begin : g_nn
            assign narrow_set[i] = 1'b0;
        end
    end

    // state selection
    always_comb begin
        if (rst || !clr_req) begin
            cmd_state = CMD_IDLE;
        end else if (clr_spec != SPEC_OK) begin
            cmd_state = CMD_BAD;
        end else if (clr_wide_mode) begin
            cmd_state = CMD_CLR_WIDE;
        end else begin
            cmd_state = CMD_CLR_NARROW;
        end
    end

    // outputs per state
    always_comb begin
        clr_mask = '0;
        fault    = 1'b0;
        unique case (cmd_state)
            CMD_IDLE:       ;
            CMD_CLR_WIDE:   clr_mask = wide_set;
            CMD_CLR_NARROW: clr_mask = narrow_set;
            CMD_BAD:        fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/vrf_store.sv
module vrf_store
    import vrf_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int MAXVL = 512,
    parameter int IDXW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [1:0]                 wr_width,
    input  logic [MAXVL-1:0]           wr_data,
    input  logic [NREG-1:0]            clr_mask,
    output logic [NREG-1:0][MAXVL-1:0] st_q
);

    localparam logic [MAXVL-1:0] ALL1   = {MAXVL{1'b1}};
    localparam logic [MAXVL-1:0] SPAN128 = ALL1 >> (MAXVL - 128);
    localparam logic [MAXVL-1:0] SPAN256 = ALL1 >> (MAXVL - 256);

    logic [MAXVL-1:0] wmask;

    always_comb begin
        unique case (wr_width)
            WW_128:  wmask = SPAN128;
            WW_256:  wmask = SPAN256;
            default: wmask = ALL1;
        endcase
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [MAXVL-1:0] merged;
        logic [MAXVL-1:0] nxt;

        always_comb begin
            merged = st_q[i];
            if (wr_en && (wr_idx == IDXW'(i))) begin
                merged = (st_q[i] & ~wmask) | (wr_data & wmask);
            end
            nxt = clr_mask[i] ? (merged & SPAN128) : merged;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= '0;
            end else begin
                st_q[i] <= nxt;
            end
        end
    end

endmodule

// File: rtl/vec_regfile.sv
module vec_regfile
    import vrf_pkg::*;
#(
    parameter int MAXVL      = 512,
    parameter int NREG       = 32,
    parameter int WIDE_CNT   = 16,
    parameter int NARROW_CNT = 8,
    parameter int IDXW       = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDXW-1:0]  rd_a_idx,
    output logic [MAXVL-1:0] rd_a_data,
    input  logic [IDXW-1:0]  rd_b_idx,
    output logic [MAXVL-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [1:0]       wr_width,
    input  logic [MAXVL-1:0] wr_data,
    input  logic             clr_req,
    input  logic             clr_wide_mode,
    input  logic [3:0]       clr_spec,
    output logic             ud_fault
);

    logic [NREG-1:0]            clr_mask;
    logic [NREG-1:0][MAXVL-1:0] st_q;

    vrf_cmd_decode #(
        .NREG(NREG), .WIDE_CNT(WIDE_CNT), .NARROW_CNT(NARROW_CNT)
    ) u_dec (
        .rst(rst), .clr_req(clr_req), .clr_wide_mode(clr_wide_mode),
        .clr_spec(clr_spec), .clr_mask(clr_mask), .fault(ud_fault)
    );

    vrf_store #(
        .NREG(NREG), .MAXVL(MAXVL), .IDXW(IDXW)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_width(wr_width), .wr_data(wr_data), .clr_mask(clr_mask),
        .st_q(st_q)
    );

    assign rd_a_data = st_q[rd_a_idx];
    assign rd_b_data = st_q[rd_b_idx];

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
    parameter int MAXVL      = 512,
    parameter int NREG       = 32,
    parameter int WIDE_CNT   = 16,
    parameter int NARROW_CNT = 8,
    parameter int IDXW       = $clog2(NREG)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [IDXW-1:0]            wr_idx,
    input logic [1:0]                 wr_width,
    input logic                       clr_req,
    input logic                       clr_wide_mode,
    input logic [3:0]                 clr_spec,
    input logic                       ud_fault,
    input logic [NREG-1:0][MAXVL-1:0] st_q
);

    logic good_clr;
    assign good_clr = clr_req && (clr_spec == 4'b1111);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    assert_reset_fault_R1: assert property (@(posedge clk)
        rst |-> !ud_fault);

    assert_bad_spec_R6: assert property (@(posedge clk) disable iff (rst)
        (ud_fault && !wr_en) |=> $stable(st_q));

    assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_req |-> !ud_fault);

    assert_narrow_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_width == 2'b00 && !clr_req)
        |=> st_q[$past(wr_idx)][MAXVL-1:128] == $past(st_q[wr_idx][MAXVL-1:128]));

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        if (i < NARROW_CNT) begin : g_lo
            assert_clear_narrow_R3: assert property (@(posedge clk) disable iff (rst)
                good_clr |=> st_q[i][MAXVL-1:128] == '0);
        end else if (i < WIDE_CNT) begin : g_mid
            assert_clear_wide_R2: assert property (@(posedge clk) disable iff (rst)
                (good_clr && clr_wide_mode) |=> st_q[i][MAXVL-1:128] == '0);
            assert_narrow_spares_R3: assert property (@(posedge clk) disable iff (rst)
                (good_clr && !clr_wide_mode && !(wr_en && wr_idx == IDXW'(i)))
                |=> $stable(st_q[i]));
        end else begin : g_hi
            assert_high_bank_R5: assert property (@(posedge clk) disable iff (rst)
                (clr_req && !(wr_en && wr_idx == IDXW'(i))) |=> $stable(st_q[i]));
        end
        if (i < WIDE_CNT) begin : g_low
            assert_low_kept_R4: assert property (@(posedge clk) disable iff (rst)
                (clr_req && !(wr_en && wr_idx == IDXW'(i)))
                |=> st_q[i][127:0] == $past(st_q[i][127:0]));
        end
    end

endmodule

bind vec_regfile vrf_checker #(
    .MAXVL(MAXVL), .NREG(NREG), .WIDE_CNT(WIDE_CNT), .NARROW_CNT(NARROW_CNT), .IDXW(IDXW)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width),
    .clr_req(clr_req), .clr_wide_mode(clr_wide_mode), .clr_spec(clr_spec),
    .ud_fault(ud_fault), .st_q(st_q)
);

// File: tb/tb_vec_regfile.sv
`timescale 1ns/1ps
module tb_vec_regfile;

    localparam int MAXVL = 512;
    localparam int NREG  = 32;
    localparam logic [MAXVL-1:0] ONES = {MAXVL{1'b1}};
    localparam logic [MAXVL-1:0] LOW128 = ONES >> (MAXVL - 128);
    localparam logic [MAXVL-1:0] LOW256 = ONES >> (MAXVL - 256);

    logic             clk = 1'b0;
    logic             rst;
    logic [4:0]       rd_a_idx, rd_b_idx, wr_idx;
    logic [MAXVL-1:0] rd_a_data, rd_b_data, wr_data;
    logic             wr_en, clr_req, clr_wide_mode, ud_fault;
    logic [1:0]       wr_width;
    logic [3:0]       clr_spec;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [MAXVL-1:0] model [NREG];

    always #2 clk = ~clk;

    vec_regfile #(.MAXVL(MAXVL)) dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width), .wr_data(wr_data),
        .clr_req(clr_req), .clr_wide_mode(clr_wide_mode), .clr_spec(clr_spec),
        .ud_fault(ud_fault)
    );

    function automatic logic [MAXVL-1:0] pat(int i, int s);
        logic [MAXVL-1:0] v;
        for (int k = 0; k < MAXVL / 32; k++) begin
            v[k*32 +: 32] = (32'h9E3779B9 * 32'(i + 1)) ^ (32'(k) * 32'h01000193)
                            ^ (32'(s) * 32'h00010001);
        end
        return v;
    endfunction

    task automatic chk(string req, logic [MAXVL-1:0] act, logic [MAXVL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one operation: write and clear fields driven together
    task automatic step(bit we, int wi, logic [1:0] ww, logic [MAXVL-1:0] wd,
                        bit cr, bit cm, logic [3:0] cs);
        logic [MAXVL-1:0] m;
        @(negedge clk);
        wr_en = we; wr_idx = 5'(wi); wr_width = ww; wr_data = wd;
        clr_req = cr; clr_wide_mode = cm; clr_spec = cs;
        #1;
        chk(cr ? "R6 fault level" : "R7 fault idle",
            MAXVL'(ud_fault), MAXVL'(cr && cs != 4'hF));
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; clr_req = 1'b0;
        if (we) begin
            m = (ww == 2'b00) ? LOW128 : (ww == 2'b01) ? LOW256 : ONES;
            model[wi] = (model[wi] & ~m) | (wd & m);
        end
        if (cr && cs == 4'hF) begin
            for (int i = 0; i < (cm ? 16 : 8); i++) model[i] = model[i] & LOW128;
        end
        #1;
        chk("R7 pulse ends", MAXVL'(ud_fault), '0);
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < NREG; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(NREG - 1 - i);
            #0.1;
            chk($sformatf("%s reg%0d portA R10", tag, i), rd_a_data, model[i]);
            chk($sformatf("%s reg%0d portB R10", tag, NREG - 1 - i), rd_b_data,
                model[NREG - 1 - i]);
        end
    endtask

    task automatic fill_all(int seed);
        for (int i = 0; i < NREG; i++) step(1'b1, i, 2'b10, pat(i, seed), 1'b0, 1'b0, 4'h0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_width = '0; wr_data = '0;
        clr_req = 1'b0; clr_wide_mode = 1'b0; clr_spec = '0;
        rd_a_idx = '0; rd_b_idx = '0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        // drive garbage during reset: fault must stay low, contents zero
        @(negedge clk);
        wr_en = 1'b1; wr_data = ONES; wr_width = 2'b10;
        clr_req = 1'b1; clr_spec = 4'h3;
        #1;
        chk("R1 fault in reset", MAXVL'(ud_fault), '0);
        repeat (3) @(negedge clk);
        wr_en = 1'b0; clr_req = 1'b0;
        rst = 1'b0;
        check_all("R1 reset");

        // width sweep on every register
        for (int i = 0; i < NREG; i++) begin
            for (int w = 0; w < 4; w++) begin
                step(1'b1, i, 2'(w), pat(i, w * 7 + 1), 1'b0, 1'b0, 4'h0);
                rd_a_idx = 5'(i); rd_b_idx = 5'(i);
                #0.1;
                chk($sformatf("R8 width%0d reg%0d", w, i), rd_a_data, model[i]);
                chk($sformatf("R10 portB reg%0d", i), rd_b_data, model[i]);
            end
        end

        // mode x specifier sweep
        for (int md = 0; md < 2; md++) begin
            for (int sp = 0; sp < 16; sp++) begin
                fill_all(md * 16 + sp + 100);
                step(1'b0, 0, 2'b00, '0, 1'b1, md[0], 4'(sp));
                check_all(sp != 15 ? "R6 bad spec R5" :
                          md == 1 ? "R2 R4 R5" : "R3 R4 R5");
            end
        end

        // write colliding with clear in the same cycle
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 2; s++) begin
                foreach (model[t]) begin
                    if (t == 3 || t == 12 || t == 20) begin
                        fill_all(300 + t + md * 5 + s);
                        step(1'b1, t, 2'b10, pat(t, 999 + md), 1'b1, md[0],
                             s == 0 ? 4'hF : 4'hE);
                        check_all(s == 0 ? "R9 collide R5" : "R6 write with bad spec");
                    end
                end
            end
        end

        // narrow write into a cleared register keeps zero upper bits
        step(1'b0, 0, 2'b00, '0, 1'b1, 1'b1, 4'hF);
        step(1'b1, 5, 2'b00, pat(5, 77), 1'b0, 1'b0, 4'h0);
        check_all("R8 after clear");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule